// File: doc/BRIEF.md
# Multi-Lane PRBS23 Test Pattern Generator

This block produces a self-test byte stream for a four-lane 10-gigabit attachment link, placed ahead of the 8b/10b encoders. Every cycle, each lane presents one byte and one flag that marks the byte as a control code. The stream is a series of packets. Each packet opens with a fixed run of comma characters, which lets a receiver find byte and lane alignment and adjust elasticity. A pseudo-random payload follows. The packets repeat for as long as the generator stays enabled.

Three payload shapes can be selected. Full mode sends the complete PRBS23 byte sequence. Short mode cuts the sequence at 13458 bytes. Jumbo mode wraps the short sequence in an Ethernet-like frame: a start code, preamble bytes and a start-of-frame delimiter spread across the lanes, and a terminate code after the data. All lanes carry the same payload, each from its own generator. A receiver built on the same rules can therefore check every lane on its own.

Top module: `bist_lane_gen`

## Requirements
- R1: While en_i is low, the next output column is a comma on every lane (data 0xBC, ctrl 1), and the next packet begins with its gap at position 0 once en_i is sampled high. After reset the output is all commas.
- R2: Every packet begins with exactly GAP_LEN (default 9) columns in which all lanes carry 0xBC with ctrl set.
- R3: Each payload byte is formed from the next eight outputs of the LFSR x^23+x^18+1 (new bit = s[22] xor s[17], shifted in at bit 0). The first bit produced goes to byte bit 7. The register is loaded with SEED at the start of every payload.
- R4: mode_i = 2'b00 (full), and 2'b11 which behaves as full, sends FULL_LEN payload bytes per lane (default 2^23-1) before the next gap.
- R5: mode_i = 2'b01 (short) sends SHORT_LEN payload bytes per lane (default 13458) before the next gap.
- R6: mode_i = 2'b10 (jumbo) sends, after the gap, a column with lane 0 = 0xFB (ctrl 1) and lanes 1-3 = 0x55 (ctrl 0). The next column has lanes 0-2 = 0x55 and lane 3 = 0xD5, all with ctrl 0. SHORT_LEN payload bytes per lane follow. Then comes one column with lane 0 = 0xFD (ctrl 1) and lanes 1-3 = 0xBC (ctrl 1), and then the next gap.
- R7: During the payload every lane carries the same byte, with ctrl 0.
- R8: mode_i is sampled only while disabled or at the clock edge that ends a packet. A change in the middle of a packet does not alter that packet.
- R9: ctrl is set only with the bytes 0xBC, 0xFB or 0xFD.
- R10: While en_i stays high, packets follow one another without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run pattern; low holds the gap start |
| mode_i | input | 2 | 00 full, 01 short, 10 jumbo, 11 full |
| data_o | output | 8*LANES | Lane bytes, lane 0 in bits 7:0 |
| ctrl_o | output | LANES | Control-code flag per lane, lane 0 in bit 0 |

## Verification
A packet wrap and a mode change can land on the same clock edge. The new mode has to be picked up exactly there, and the first packet after the wrap has to take on the new framing. The bench sets mode_i in the cycle the model reports the last column of a short packet, so the jumbo header must follow the next gap. It also changes mode_i in the middle of a full packet and expects that packet to keep its full length. Packet lengths are measured from the comma runs at the ports and compared with the length the mode in force defines, and every column is compared with a behavioural model.

// File: rtl/bist_gen_pkg.sv
package bist_gen_pkg;

  typedef enum logic [2:0] {
    PH_GAP  = 3'd0,
    PH_SOF  = 3'd1,
    PH_PRE  = 3'd2,
    PH_DATA = 3'd3,
    PH_TERM = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    MD_FULL  = 2'b00,
    MD_SHORT = 2'b01,
    MD_JUMBO = 2'b10,
    MD_ALT   = 2'b11
  } mode_t;

  localparam logic [7:0] CODE_K   = 8'hBC;
  localparam logic [7:0] CODE_S   = 8'hFB;
  localparam logic [7:0] CODE_T   = 8'hFD;
  localparam logic [7:0] BYTE_PRE = 8'h55;
  localparam logic [7:0] BYTE_SFD = 8'hD5;

endpackage

// File: rtl/bist_prbs_lane.sv
module bist_prbs_lane #(
  parameter int          WIDTH = 23,
  parameter int          TAP   = 18,
  parameter int          BITS  = 8,
  parameter logic [22:0] SEED  = 23'h2A5F3C
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  output logic [BITS-1:0] byte_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;

  // unroll BITS serial shifts; first bit lands in the MSB
  always_comb begin
    logic [WIDTH-1:0] s;
    logic             fb;
    s      = state_q;
    byte_o = '0;
    for (int i = 0; i < BITS; i++) begin
      fb                = s[WIDTH-1] ^ s[TAP-1];
      byte_o[BITS-1-i]  = fb;
      s                 = {s[WIDTH-2:0], fb};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEED[WIDTH-1:0];
    else if (load_i)  state_q <= SEED[WIDTH-1:0];
    else if (step_i)  state_q <= state_nxt;
  end

endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_gen_pkg::*;
#(
  parameter int GAP_LEN   = 9,
  parameter int FULL_LEN  = 8388607,
  parameter int SHORT_LEN = 13458
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output phase_t     phase_o
);

  localparam int MAX_A = (FULL_LEN > SHORT_LEN) ? FULL_LEN : SHORT_LEN;
  localparam int MAX_L = (MAX_A > GAP_LEN) ? MAX_A : GAP_LEN;
  localparam int CW    = $clog2(MAX_L + 1);

  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_LEN - 1);
  localparam logic [CW-1:0] FULL_LAST  = CW'(FULL_LEN - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);

  phase_t        phase_q;
  mode_t         mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pay_last;
  logic          jumbo;

  assign jumbo    = (mode_q == MD_JUMBO);
  assign pay_last = (mode_q == MD_SHORT || mode_q == MD_JUMBO) ? SHORT_LAST : FULL_LAST;
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_GAP;
      cnt_q   <= '0;
      mode_q  <= MD_FULL;
    end else if (!en_i) begin
      phase_q <= PH_GAP;
      cnt_q   <= '0;
      mode_q  <= mode_t'(mode_i);
    end else begin
      unique case (phase_q)
        PH_GAP: begin
          if (cnt_q == GAP_LAST) begin
            cnt_q   <= '0;
            phase_q <= jumbo ? PH_SOF : PH_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SOF: phase_q <= PH_PRE;
        PH_PRE: phase_q <= PH_DATA;
        PH_DATA: begin
          if (cnt_q == pay_last) begin
            cnt_q <= '0;
            if (jumbo) begin
              phase_q <= PH_TERM;
            end else begin
              phase_q <= PH_GAP;
              mode_q  <= mode_t'(mode_i);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_TERM: begin
          phase_q <= PH_GAP;
          mode_q  <= mode_t'(mode_i);
        end
        default: begin
          phase_q <= PH_GAP;
          cnt_q   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/bist_lane_mux.sv
module bist_lane_mux
  import bist_gen_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int LANES = 4
) (
  input  phase_t     phase_i,
  input  logic [7:0] prbs_i,
  output logic [7:0] data_o,
  output logic       ctrl_o
);

  localparam bit FIRST = (LANE == 0);
  localparam bit LAST  = (LANE == LANES - 1);

  always_comb begin
    data_o = CODE_K;
    ctrl_o = 1'b1;
    unique case (phase_i)
      PH_GAP: begin
        data_o = CODE_K;
        ctrl_o = 1'b1;
      end
      PH_SOF: begin
        data_o = FIRST ? CODE_S : BYTE_PRE;
        ctrl_o = FIRST;
      end
      PH_PRE: begin
        data_o = LAST ? BYTE_SFD : BYTE_PRE;
        ctrl_o = 1'b0;
      end
      PH_DATA: begin
        data_o = prbs_i;
        ctrl_o = 1'b0;
      end
      PH_TERM: begin
        data_o = FIRST ? CODE_T : CODE_K;
        ctrl_o = 1'b1;
      end
      default: begin
        data_o = CODE_K;
        ctrl_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bist_lane_gen.sv
module bist_lane_gen
  import bist_gen_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          GAP_LEN   = 9,
  parameter int          FULL_LEN  = 8388607,
  parameter int          SHORT_LEN = 13458,
  parameter logic [22:0] SEED      = 23'h2A5F3C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [1:0]         mode_i,
  output logic [8*LANES-1:0] data_o,
  output logic [LANES-1:0]   ctrl_o
);

  phase_t phase;
  logic   data_phase;
  logic   prbs_load;
  logic   prbs_step;

  bist_seq #(
    .GAP_LEN  (GAP_LEN),
    .FULL_LEN (FULL_LEN),
    .SHORT_LEN(SHORT_LEN)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .phase_o(phase)
  );

  assign data_phase = (phase == PH_DATA);
  assign prbs_load  = !data_phase;
  assign prbs_step  = data_phase && en_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] prbs_byte;

    bist_prbs_lane #(
      .WIDTH(23),
      .TAP  (18),
      .BITS (8),
      .SEED (SEED)
    ) u_prbs (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(prbs_load),
      .step_i(prbs_step),
      .byte_o(prbs_byte)
    );

    bist_lane_mux #(
      .LANE (l),
      .LANES(LANES)
    ) u_mux (
      .phase_i(phase),
      .prbs_i (prbs_byte),
      .data_o (data_o[8*l +: 8]),
      .ctrl_o (ctrl_o[l])
    );
  end

endmodule

// File: rtl/bist_lane_gen_chk.sv
module bist_lane_gen_chk #(
  parameter int LANES   = 4,
  parameter int GAP_LEN = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [8*LANES-1:0] data_o,
  input logic [LANES-1:0]   ctrl_o,
  input logic               data_phase_i
);

  localparam int RW = $clog2(GAP_LEN + 2);

  logic          comma_col;
  logic [RW-1:0] run_q;

  assign comma_col = ctrl_o[0] && (data_o[7:0] == 8'hBC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (!en_i)     run_q <= '0;
    else if (comma_col) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R1
  dis_comma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ctrl_o == {LANES{1'b1}}) && (data_o == {LANES{8'hBC}}));

  // R2
  gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && comma_col) |-> (run_q < RW'(GAP_LEN)));

  // R7
  lanes_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_phase_i |-> (ctrl_o == '0) && (data_o == {LANES{data_o[7:0]}}));

  // R6
  sof_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ctrl_o[0] && data_o[7:0] == 8'hFB) |=>
      (data_o[8*LANES-1 -: 8] == 8'hD5) && (ctrl_o == '0));

  // R6
  term_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ctrl_o[0] && data_o[7:0] == 8'hFD) |=> comma_col);

  for (genvar l = 0; l < LANES; l++) begin : g_code
    // R9
    ctrl_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_o[l] |-> (data_o[8*l +: 8] == 8'hBC || data_o[8*l +: 8] == 8'hFB ||
                     data_o[8*l +: 8] == 8'hFD));
  end

endmodule

bind bist_lane_gen bist_lane_gen_chk #(
  .LANES  (LANES),
  .GAP_LEN(GAP_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .data_o      (data_o),
  .ctrl_o      (ctrl_o),
  .data_phase_i(data_phase)
);

// File: tb/bist_lane_gen_bench.sv
`timescale 1ns/1ps
module bist_lane_gen_bench;

  localparam int          LANES = 4;
  localparam int          GAP   = 9;
  localparam int          FULL  = 40;
  localparam int          SHORT = 13458;
  localparam logic [22:0] SEED  = 23'h2A5F3C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [8*LANES-1:0] data;
  logic [LANES-1:0]  ctrl;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bist_lane_gen #(
    .LANES(LANES), .GAP_LEN(GAP), .FULL_LEN(FULL), .SHORT_LEN(SHORT), .SEED(SEED)
  ) u_bist_lane_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .data_o(data), .ctrl_o(ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pay_len(input logic [1:0] m);
    return (m == 2'b01 || m == 2'b10) ? SHORT : FULL;
  endfunction

  function automatic int pkt_len(input logic [1:0] m);
    return (m == 2'b10) ? GAP + 3 + SHORT : GAP + pay_len(m);
  endfunction

  function automatic int pay_start(input logic [1:0] m);
    return (m == 2'b10) ? GAP + 2 : GAP;
  endfunction

  // behavioural reference: packet position, latched mode, LFSR
  int          m_p    = 0;
  logic [1:0]  m_mode = 2'b00;
  logic [22:0] m_lfsr = SEED;
  bit          m_dis  = 1'b1;

  function automatic logic [7:0] lfsr_byte(input logic [22:0] s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      b[7-i] = s[22] ^ s[17];
      s = {s[21:0], s[22] ^ s[17]};
    end
    return b;
  endfunction

  function automatic logic [22:0] lfsr_adv(input logic [22:0] s);
    for (int i = 0; i < 8; i++) s = {s[21:0], s[22] ^ s[17]};
    return s;
  endfunction

  function automatic bit in_pay(input int p, input logic [1:0] m);
    return p >= pay_start(m) && p < pay_start(m) + pay_len(m);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p = 0; m_mode = 2'b00; m_lfsr = SEED; m_dis = 1'b1;
    end else if (!en) begin
      m_p = 0; m_mode = mode; m_lfsr = SEED; m_dis = 1'b1;
    end else begin
      m_dis = 1'b0;
      if (in_pay(m_p, m_mode)) m_lfsr = lfsr_adv(m_lfsr);
      if (m_p == pkt_len(m_mode) - 1) begin
        m_p = 0; m_mode = mode; m_lfsr = SEED;
      end else begin
        m_p++;
      end
    end
  end

  // port-side packet length measurement
  int         cyc = 0;
  int         start_cyc = 0;
  logic [1:0] start_mode = 2'b00;
  bit         have_start = 1'b0;
  bit         prev_k = 1'b1;
  bit         mid_chg = 1'b0;
  int         pkts = 0;

  always @(negedge clk) begin
    logic [31:0] ed;
    logic [3:0]  ec;
    string       tag;
    bit          col_k;
    cyc++;
    if (rst_n) begin
      ed = '0; ec = '0;
      if (m_dis) tag = "R1";
      else if (m_p < GAP) tag = "R2";
      else if (in_pay(m_p, m_mode)) tag = "R3";
      else tag = "R6";
      for (int l = 0; l < LANES; l++) begin
        if (m_p < GAP) begin
          ed[8*l +: 8] = 8'hBC; ec[l] = 1'b1;
        end else if (in_pay(m_p, m_mode)) begin
          ed[8*l +: 8] = lfsr_byte(m_lfsr); ec[l] = 1'b0;
        end else if (m_p == GAP) begin
          ed[8*l +: 8] = (l == 0) ? 8'hFB : 8'h55; ec[l] = (l == 0);
        end else if (m_p == GAP + 1) begin
          ed[8*l +: 8] = (l == LANES - 1) ? 8'hD5 : 8'h55; ec[l] = 1'b0;
        end else begin
          ed[8*l +: 8] = (l == 0) ? 8'hFD : 8'hBC; ec[l] = 1'b1;
        end
      end
      chk(tag, data, ed);
      chk(tag, {28'd0, ctrl}, {28'd0, ec});
      // R9: control flag only on the three control codes
      for (int l = 0; l < LANES; l++)
        if (ctrl[l])
          chk("R9", {31'd0, data[8*l +: 8] inside {8'hBC, 8'hFB, 8'hFD}}, 32'd1);
      // R7: identical lanes during payload
      if (!m_dis && in_pay(m_p, m_mode))
        for (int l = 1; l < LANES; l++)
          chk("R7", {24'd0, data[8*l +: 8]}, {24'd0, data[7:0]});

      col_k = ctrl[0] && data[7:0] == 8'hBC;
      if (m_dis) begin
        have_start = 1'b0;
      end else if (col_k && !prev_k) begin
        if (have_start) begin
          if (mid_chg) tag = "R8";
          else if (start_mode == 2'b01) tag = "R5";
          else if (start_mode == 2'b10) tag = "R6";
          else tag = "R4";
          chk(tag, cyc - start_cyc, pkt_len(start_mode));
          mid_chg = 1'b0;
        end
        start_cyc  = cyc;
        start_mode = m_mode;
        have_start = 1'b1;
        pkts++;
      end
      prev_k = col_k;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", data, {LANES{8'hBC}});
    chk("R1", {28'd0, ctrl}, 32'h0000000F);
    repeat (3) @(negedge clk);
    en = 1'b1; mode = 2'b00;
    repeat (4 * (GAP + FULL) + 5) @(negedge clk);
    // R10: several full packets in a row without re-enabling
    chk("R10", {31'd0, pkts >= 4}, 32'd1);
    // R8: mid-packet change must not alter the running full packet
    while (m_p != GAP + 20) @(negedge clk);
    mode = 2'b01; mid_chg = 1'b1;
    while (!(m_mode == 2'b01 && m_p == pkt_len(m_mode) - 1)) @(negedge clk);
    // wrap and mode change on the same edge: short -> jumbo
    mode = 2'b10;
    @(negedge clk);
    @(negedge clk);
    chk("R8", {30'd0, m_mode}, 32'd2);
    repeat (2 * (GAP + 3 + SHORT) + 20) @(negedge clk);
    // R1: disable in mid-packet, then restart in alternate full mode
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", data, {LANES{8'hBC}});
    en = 1'b1; mode = 2'b11;
    repeat (3 * (GAP + FULL) + 5) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule